// File: doc/BRIEF.md
# Sampling Clock Tuning Register Block

This block is the software-visible control and status register set for a sampling-clock tap controller in an SD host running at SDR104 speeds. Software uses it to program the tap count, to enable the taps, to choose a tap position and a capture phase word, and to switch the card-side sampling from the default clock to the tuned clock. Each of these settings drives a sideband output to the delay-line logic next to it. The delay line itself is not part of this block.

Once tuning is done, software arms automatic re-tuning. The datapath reports a sampling problem with a single-cycle error pulse. The block stores that pulse in a sticky flag, and software clears the flag by writing zero. While the flag is set and re-tuning is armed, the block raises a registered re-tune request. Access is through a simple 32-bit read/write port. The byte address is a register index shifted left by a bus-shift parameter.

Top module: `stc_tune_regs`

## Requirements
- R1: After a synchronous reset, every register field is zero except the tap count, which is 8. `rd_data` and `retune_req_o` are also zero.
- R2: The byte address is the register index shifted left by `BUS_SHIFT` (default 2). An address with a nonzero bit below `BUS_SHIFT` is unmapped. The mapped indices are tap control 0x0, tap select 0x2, capture phase 0x4, clock select 0x6, re-tune control 0x8 and re-tune status 0xA. A read loads `rd_data` at the clock edge that accepts it, and that value holds until the next read.
- R3: Tap control: bit 0 is the tap enable and bits 23:16 are the tap count. Both can be read and written, and they drive `tap_enable_o` and `tap_count_o`. All other bits read as zero.
- R4: Tap select bits 7:0 drive `tap_select_o`. Capture phase bits 15:0 drive `capture_phase_o`. Both can be read and written, and their upper bits read as zero.
- R5: Clock select bit 0 can be read and written and drives `tuned_clk_sel_o`. A 1 selects the tuned sampling clock.
- R6: Re-tune control bit 1 is the auto re-tune arm. It can be read and written and drives `retune_arm_o`.
- R7: A one-cycle high on `err_pulse_i` sets the error flag at that clock edge. Software reads the flag as bit 2 of re-tune status.
- R8: A write to re-tune status with bit 2 equal to 0 clears the flag. A write with bit 2 equal to 1 has no effect. If an error pulse arrives in the same cycle as a clear, the flag stays set.
- R9: `retune_req_o` is high in the cycle after any cycle in which both the arm bit and the error flag are set, and low otherwise.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses change nothing.
- R11: A register write updates its sideband output at the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_pulse_i | input | 1 | Single-cycle re-tuning error from the datapath |
| tap_enable_o | output | 1 | Tap enable |
| tap_count_o | output | CNT_W | Tap count |
| tap_select_o | output | TAP_W | Selected tap position |
| capture_phase_o | output | CAPT_W | Capture phase word |
| tuned_clk_sel_o | output | 1 | Selects the tuned sampling clock |
| retune_arm_o | output | 1 | Auto re-tune armed |
| retune_req_o | output | 1 | Re-tune request to software |

## Verification
Writes and error pulses take effect at the clock edge that accepts them. Read data becomes valid one register stage later, at the same edge. The re-tune request follows the flag and the arm bit one edge after that. The bench applies each stimulus after a falling edge and samples every output 1 ns after the next rising edge. It compares the read data and sidebands against a model updated for that edge, and it compares the request against the arm and flag state from before that edge.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int NREG = 6;
  localparam int unsigned REG_INDEX [NREG] = '{32'h0, 32'h2, 32'h4, 32'h6, 32'h8, 32'hA};
  localparam int SEL_TAPCTL = 0;
  localparam int SEL_TAPSEL = 1;
  localparam int SEL_CAPT   = 2;
  localparam int SEL_CKSEL  = 3;
  localparam int SEL_RTCTL  = 4;
  localparam int SEL_RTSTAT = 5;
  localparam int TAPEN_BIT  = 0;
  localparam int CNT_LSB    = 16;
  localparam int CKSEL_BIT  = 0;
  localparam int ARM_BIT    = 1;
  localparam int ERR_BIT    = 2;
endpackage

// File: rtl/stc_addr_dec.sv
module stc_addr_dec
  import stc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUS_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  localparam int IDX_W = ADDR_W - BUS_SHIFT;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BUS_SHIFT) - 1);

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = ((addr & LOW_MASK) == '0);
  assign idx     = addr[ADDR_W-1:BUS_SHIFT];

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = aligned && (idx == IDX_W'(REG_INDEX[g]));
  end
endmodule

// File: rtl/stc_cfg_regs.sv
module stc_cfg_regs
  import stc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TAP_W      = 8,
  parameter int CAPT_W     = 16,
  parameter int TAPCNT_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   we,
  input  logic [31:0]       wdata,
  output logic              tap_en,
  output logic [CNT_W-1:0]  tap_cnt,
  output logic [TAP_W-1:0]  tap_pos,
  output logic [CAPT_W-1:0] capt,
  output logic              ck_sel,
  output logic              arm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_en  <= 1'b0;
      tap_cnt <= CNT_W'(TAPCNT_RST);
      tap_pos <= '0;
      capt    <= '0;
      ck_sel  <= 1'b0;
      arm     <= 1'b0;
    end else begin
      if (we[SEL_TAPCTL]) begin
        tap_en  <= wdata[TAPEN_BIT];
        tap_cnt <= wdata[CNT_LSB +: CNT_W];
      end
      if (we[SEL_TAPSEL]) tap_pos <= wdata[TAP_W-1:0];
      if (we[SEL_CAPT])   capt    <= wdata[CAPT_W-1:0];
      if (we[SEL_CKSEL])  ck_sel  <= wdata[CKSEL_BIT];
      if (we[SEL_RTCTL])  arm     <= wdata[ARM_BIT];
    end
  end
endmodule

// File: rtl/stc_err_flag.sv
module stc_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/stc_tune_regs.sv
module stc_tune_regs
  import stc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BUS_SHIFT  = 2,
  parameter int CNT_W      = 8,
  parameter int TAP_W      = 8,
  parameter int CAPT_W     = 16,
  parameter int TAPCNT_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic              err_pulse_i,
  output logic              tap_enable_o,
  output logic [CNT_W-1:0]  tap_count_o,
  output logic [TAP_W-1:0]  tap_select_o,
  output logic [CAPT_W-1:0] capture_phase_o,
  output logic              tuned_clk_sel_o,
  output logic              retune_arm_o,
  output logic              retune_req_o
);
  logic [NREG-1:0] reg_hit;
  logic [NREG-1:0] reg_we;
  logic            err_clr;
  logic            err_flag_q;
  logic [31:0]     rd_mux;

  stc_addr_dec #(.ADDR_W(ADDR_W), .BUS_SHIFT(BUS_SHIFT)) u_dec (
    .addr (req_addr),
    .hit  (reg_hit)
  );

  assign reg_we  = (req_valid && req_write) ? reg_hit : '0;
  assign err_clr = reg_we[SEL_RTSTAT] && !req_wdata[ERR_BIT];

  stc_cfg_regs #(
    .CNT_W(CNT_W), .TAP_W(TAP_W), .CAPT_W(CAPT_W), .TAPCNT_RST(TAPCNT_RST)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .wdata   (req_wdata),
    .tap_en  (tap_enable_o),
    .tap_cnt (tap_count_o),
    .tap_pos (tap_select_o),
    .capt    (capture_phase_o),
    .ck_sel  (tuned_clk_sel_o),
    .arm     (retune_arm_o)
  );

  stc_err_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (err_pulse_i),
    .clr_i  (err_clr),
    .flag_o (err_flag_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      reg_hit[SEL_TAPCTL]: rd_mux = (32'(tap_count_o) << CNT_LSB) | (32'(tap_enable_o) << TAPEN_BIT);
      reg_hit[SEL_TAPSEL]: rd_mux = 32'(tap_select_o);
      reg_hit[SEL_CAPT]:   rd_mux = 32'(capture_phase_o);
      reg_hit[SEL_CKSEL]:  rd_mux = 32'(tuned_clk_sel_o) << CKSEL_BIT;
      reg_hit[SEL_RTCTL]:  rd_mux = 32'(retune_arm_o) << ARM_BIT;
      reg_hit[SEL_RTSTAT]: rd_mux = 32'(err_flag_q) << ERR_BIT;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      retune_req_o <= 1'b0;
    end else begin
      if (req_valid && !req_write) rd_data <= rd_mux;
      retune_req_o <= retune_arm_o && err_flag_q;
    end
  end
endmodule

// File: rtl/stc_checks.sv
module stc_checks #(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int TAPCNT_RST = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rd_data,
  input logic [5:0]        reg_hit,
  input logic              err_pulse_i,
  input logic              err_flag_q,
  input logic [CNT_W-1:0]  tap_count_o,
  input logic              retune_arm_o,
  input logic              retune_req_o
);
  logic clr_req;
  assign clr_req = req_valid && req_write && reg_hit[5] && !req_wdata[2];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (tap_count_o == CNT_W'(TAPCNT_RST)) && !retune_req_o && !err_flag_q && (rd_data == 32'h0));

  assert_err_sets_R7: assert property (@(posedge clk) disable iff (rst)
    err_pulse_i |=> err_flag_q);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !err_pulse_i) |=> !err_flag_q);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err_flag_q && !clr_req) |=> err_flag_q);

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (rst)
    retune_req_o |-> $past(retune_arm_o && err_flag_q));

  assert_req_raised_R9: assert property (@(posedge clk) disable iff (rst)
    (retune_arm_o && err_flag_q) |=> retune_req_o);

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (reg_hit == 6'b0)) |=> (rd_data == 32'h0));
endmodule

bind stc_tune_regs stc_checks #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAPCNT_RST(TAPCNT_RST)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .rd_data      (rd_data),
  .reg_hit      (reg_hit),
  .err_pulse_i  (err_pulse_i),
  .err_flag_q   (err_flag_q),
  .tap_count_o  (tap_count_o),
  .retune_arm_o (retune_arm_o),
  .retune_req_o (retune_req_o)
);

// File: tb/stc_tune_regs_tb.sv
`timescale 1ns/1ps
module stc_tune_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        err_pulse_i = 1'b0;
  logic [31:0] rd_data;
  logic        tap_enable_o;
  logic [7:0]  tap_count_o;
  logic [7:0]  tap_select_o;
  logic [15:0] capture_phase_o;
  logic        tuned_clk_sel_o;
  logic        retune_arm_o;
  logic        retune_req_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit          m_en, m_sel, m_arm, m_flag;
  logic [7:0]  m_cnt, m_pos;
  logic [15:0] m_cap;
  logic [31:0] m_rd;

  always #2.5 clk = ~clk;

  stc_tune_regs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .err_pulse_i(err_pulse_i), .tap_enable_o(tap_enable_o), .tap_count_o(tap_count_o),
    .tap_select_o(tap_select_o), .capture_phase_o(capture_phase_o),
    .tuned_clk_sel_o(tuned_clk_sel_o), .retune_arm_o(retune_arm_o),
    .retune_req_o(retune_req_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int map_ix(logic [7:0] a);
    if (a[1:0] != 2'b0) return -1;
    case (a[7:2])
      6'h0: return 0;
      6'h2: return 1;
      6'h4: return 2;
      6'h6: return 3;
      6'h8: return 4;
      6'hA: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int ix);
    case (ix)
      0: return {8'h0, m_cnt, 15'h0, m_en};
      1: return {24'h0, m_pos};
      2: return {16'h0, m_cap};
      3: return {31'h0, m_sel};
      4: return {30'h0, m_arm, 1'b0};
      5: return {29'h0, m_flag, 2'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_sel = 0; m_arm = 0; m_flag = 0;
    m_cnt = 8'd8; m_pos = '0; m_cap = '0; m_rd = '0;
  endtask

  // One bus cycle: drive after the falling edge, sample 1 ns after the rising edge.
  task automatic cycle(bit v, bit w, logic [7:0] a, logic [31:0] d, bit p);
    int  ix;
    bit  exp_req, clr;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; err_pulse_i = p;
    ix = map_ix(a);
    exp_req = m_arm & m_flag;
    clr = 0;
    if (v && !w) m_rd = model_read(ix);
    if (v && w) begin
      case (ix)
        0: begin m_en = d[0]; m_cnt = d[23:16]; end
        1: m_pos = d[7:0];
        2: m_cap = d[15:0];
        3: m_sel = d[0];
        4: m_arm = d[1];
        5: clr = !d[2];
        default: ;
      endcase
    end
    m_flag = p | (m_flag & !clr);
    @(posedge clk);
    #1;
    check((ix < 0) ? "R10 read data" : "R2 read data", rd_data, m_rd);
    check("R3 tap control outputs", {23'h0, tap_enable_o, tap_count_o}, {23'h0, m_en, m_cnt});
    check("R4 tap select/capture outputs", {8'h0, tap_select_o, capture_phase_o}, {8'h0, m_pos, m_cap});
    check("R5 R6 R11 clock select and arm", {30'h0, tuned_clk_sel_o, retune_arm_o}, {30'h0, m_sel, m_arm});
    check("R9 retune request", {31'h0, retune_req_o}, {31'h0, exp_req});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0.5;
    // R1 reset state
    check("R1 reset tap count", {24'h0, tap_count_o}, 32'd8);
    check("R1 reset outputs", {26'h0, tap_enable_o, tuned_clk_sel_o, retune_arm_o, retune_req_o, |tap_select_o, |capture_phase_o}, 32'h0);
    check("R1 reset read data", rd_data, 32'h0);
    cycle(1, 0, 8'h00, 0, 0);              // R1: tap control reads count 8
    check("R1 tap control value", rd_data, 32'h0008_0000);

    cycle(1, 1, 8'h00, 32'hFFFF_FFFF, 0);  // R3: only mapped bits stick
    cycle(1, 0, 8'h00, 0, 0);
    check("R3 masked readback", rd_data, 32'h00FF_0001);
    cycle(1, 1, 8'h08, 32'hFFFF_FFA5, 0);  // R4
    cycle(1, 1, 8'h10, 32'h1234_5703, 0);
    cycle(1, 0, 8'h10, 0, 0);
    check("R4 capture readback", rd_data, 32'h0000_5703);
    cycle(1, 1, 8'h18, 32'h1, 0);          // R5
    cycle(1, 1, 8'h09, 32'h0, 0);          // R2: misaligned write ignored
    cycle(1, 1, 8'h0C, 32'hFFFF_FFFF, 0);  // R10: unmapped write ignored
    cycle(1, 0, 8'h0C, 0, 0);              // R10: unmapped read zero
    cycle(1, 0, 8'h09, 0, 0);              // R2: misaligned read zero

    cycle(0, 0, 8'h00, 0, 1);              // R7: flag set, arm off
    cycle(1, 0, 8'h28, 0, 0);
    check("R7 flag readback", rd_data, 32'h4);
    cycle(1, 1, 8'h20, 32'h2, 0);          // R6: arm; R9 request follows
    cycle(0, 0, 8'h00, 0, 0);
    check("R9 request asserted", {31'h0, retune_req_o}, 32'h1);
    cycle(1, 1, 8'h28, 32'h4, 0);          // R8: writing bit2=1 no effect
    cycle(1, 1, 8'h28, 32'h0, 1);          // R8: pulse wins over clear
    cycle(1, 0, 8'h28, 0, 0);
    check("R8 pulse wins over clear", rd_data, 32'h4);
    cycle(1, 1, 8'h28, 32'h0, 0);          // R8: clear
    cycle(1, 0, 8'h28, 0, 0);
    check("R8 cleared flag", rd_data, 32'h0);
    cycle(0, 0, 8'h00, 0, 0);
    check("R9 request dropped", {31'h0, retune_req_o}, 32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      a = 8'(($urandom % 16) << 2);
      if (($urandom % 8) == 0) a = a | 8'(1 + $urandom % 3);
      cycle(($urandom % 4) != 0, $urandom % 2, a, $urandom, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule